// File: doc/BRIEF.md
# Branching Microprogram Sequencer

This block is the sequencing half of a microcoded control unit. A micro-program counter addresses a resident control store. Each fetched control word is captured into a microinstruction register, and that register's control field drives the datapath for one clock. The same control word also decides the next micro-address.

That choice is made by a four-way next-address selector. Its sources are:
- the incremented micro-PC;
- a per-opcode start address taken from a mapping table;
- an externally supplied vector;
- the branch-target field of the word.

Every source other than the increment path is gated by a branch condition. The condition is unconditional, or on Z, or on N. When the condition is false, the sequencer falls back to the increment path. This is enough for instruction dispatch, forced entry (reset, interrupt, fetch restart) and microcode loops.

The resident program has the following routines:
- Fetch at 0 and an unconditional dispatch at 1.
- Opcode 0: a two-step routine at 16.
- Opcode 1: a two-word loop at 32/33 that leaves to 40 once Z is seen.
- Opcode 2: a routine at 202 that vectors externally on Z and jumps to 300 on N.
- Opcode 3: a routine at 60 that exercises a never-taken branch and an either-flag branch.
- An external entry at 100 that returns to fetch.

Top module: `useq_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, `upc_out` is 0 and `ctrl_out` is all-zero.
- R2: `ctrl_out` equals the control field of the word that was fetched at `upc_out` in the previous cycle.
- R3: The next-source code sits in bits [4:3] of a control word. The code 00 loads micro-PC + 1, wrapping from 511 to 0.
- R4: Source code 01 with a true condition loads the opcode's start address: 0→16, 1→32, 2→202, 3→60.
- R5: Source code 10 with a true condition loads `ext_addr`.
- R6: Source code 11 with a true condition loads the word's branch-target field, bits [13:5].
- R7: The condition is true when the unconditional bit (bit 2) is set, or when the Z-test bit (bit 1) is set and `flag_z` is 1, or when the N-test bit (bit 0) is set and `flag_n` is 1. When it is false, the micro-PC takes micro-PC + 1. The control field occupies bits [21:14].
- R8: For a word with source code 00, `opcode`, `flag_z`, `flag_n` and `ext_addr` have no effect on the next micro-PC.
- R9: After reset the sequence runs 0 → 1 → the mapped start address. Every routine ends by branching back to 0.
- R10: The loop at 32/33 repeats while Z is 0. When Z is 1 while word 32 is fetched, it exits to 40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 2 | Opcode of the current instruction, used by the dispatch source |
| flag_z | input | 1 | Zero flag from the datapath |
| flag_n | input | 1 | Negative flag from the datapath |
| ext_addr | input | 9 | Externally forced micro-address |
| ctrl_out | output | 8 | Control field of the microinstruction register |
| upc_out | output | 9 | Current micro-PC, the address being fetched |

## Verification
The checker assumes that `opcode`, `flag_z`, `flag_n` and `ext_addr` are stable around the rising edge. These inputs are sampled in the cycle when the deciding word is fetched. The stimulus therefore changes them only at falling edges.

The external vectors the stimulus selects are 0, 32, 100, 202 and 511. They keep the run inside the resident program, except for one deliberate landing on the last address to exercise the wrap. Flags are held fixed through directed passes and drawn freely in a final mixed pass. A zero-filled word at 511 reaches fetch again through the increment wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;

    parameter int UPC_W  = 9;
    parameter int CTRL_W = 8;
    parameter int OPC_W  = 2;

    localparam int STORE_DEPTH = 1 << UPC_W;
    localparam int WORD_W      = CTRL_W + UPC_W + 5;

    // next-address source, encoded in the word
    typedef enum logic [1:0] {
        NX_INC = 2'b00,
        NX_MAP = 2'b01,
        NX_EXT = 2'b10,
        NX_BR  = 2'b11
    } nx_src_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [UPC_W-1:0]  target;
        nx_src_e           src;
        logic              always_go;
        logic              test_z;
        logic              test_n;
    } cword_t;

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output cword_t           word
);

    function automatic cword_t mk(input int c, input nx_src_e s, input logic g,
                                  input logic tz, input logic tn, input int t);
        cword_t w;
        w.ctrl      = CTRL_W'(c);
        w.target    = UPC_W'(t);
        w.src       = s;
        w.always_go = g;
        w.test_z    = tz;
        w.test_n    = tn;
        return w;
    endfunction

    // resident microprogram; unlisted addresses hold a zero word (increment)
    function automatic cword_t program_word(input logic [UPC_W-1:0] a);
        cword_t w;
        case (int'(a))
            0:   w = mk('h01, NX_INC, 1'b0, 1'b0, 1'b0, 0);
            1:   w = mk('h02, NX_MAP, 1'b1, 1'b0, 1'b0, 0);
            16:  w = mk('h10, NX_INC, 1'b0, 1'b0, 1'b0, 0);
            17:  w = mk('h11, NX_BR,  1'b1, 1'b0, 1'b0, 0);
            32:  w = mk('h20, NX_BR,  1'b0, 1'b1, 1'b0, 40);
            33:  w = mk('h21, NX_BR,  1'b1, 1'b0, 1'b0, 32);
            40:  w = mk('h28, NX_BR,  1'b1, 1'b0, 1'b0, 0);
            60:  w = mk('h50, NX_BR,  1'b0, 1'b0, 1'b0, 0);
            61:  w = mk('h51, NX_BR,  1'b0, 1'b1, 1'b1, 0);
            62:  w = mk('h52, NX_BR,  1'b1, 1'b0, 1'b0, 0);
            100: w = mk('h60, NX_BR,  1'b1, 1'b0, 1'b0, 0);
            202: w = mk('h32, NX_EXT, 1'b0, 1'b1, 1'b0, 0);
            203: w = mk('h33, NX_BR,  1'b0, 1'b0, 1'b1, 300);
            204: w = mk('h34, NX_BR,  1'b1, 1'b0, 1'b0, 0);
            300: w = mk('h40, NX_BR,  1'b1, 1'b0, 1'b0, 0);
            default: w = '0;
        endcase
        return w;
    endfunction

    always_comb begin
        word = program_word(addr);
    end

endmodule

// File: rtl/useq_map.sv
module useq_map
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] start
);

    always_comb begin
        case (int'(opcode))
            0:       start = UPC_W'(16);
            1:       start = UPC_W'(32);
            2:       start = UPC_W'(202);
            3:       start = UPC_W'(60);
            default: start = '0;
        endcase
    end

endmodule

// File: rtl/useq_nextsel.sv
module useq_nextsel
    import useq_pkg::*;
(
    input  cword_t           word,
    input  logic [UPC_W-1:0] upc,
    input  logic [UPC_W-1:0] map_addr,
    input  logic [UPC_W-1:0] ext_addr,
    input  logic             flag_z,
    input  logic             flag_n,
    output logic [UPC_W-1:0] next_upc
);

    logic    cond_ok;
    nx_src_e route;

    always_comb begin
        cond_ok = word.always_go | (word.test_z & flag_z) | (word.test_n & flag_n);
        route   = (cond_ok) ? word.src : NX_INC;
    end

    always_comb begin
        unique case (route)
            NX_INC: next_upc = upc + UPC_W'(1);
            NX_MAP: next_upc = map_addr;
            NX_EXT: next_upc = ext_addr;
            NX_BR:  next_upc = word.target;
            default: next_upc = upc + UPC_W'(1);
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic [UPC_W-1:0]  ext_addr,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic [UPC_W-1:0]  upc_out
);

    logic [UPC_W-1:0]  upc_q;
    logic [CTRL_W-1:0] uir_ctrl_q;
    cword_t            fetch_w;
    logic [UPC_W-1:0]  map_addr;
    logic [UPC_W-1:0]  next_upc;

    useq_store u_store (
        .addr (upc_q),
        .word (fetch_w)
    );

    useq_map u_map (
        .opcode (opcode),
        .start  (map_addr)
    );

    useq_nextsel u_next (
        .word     (fetch_w),
        .upc      (upc_q),
        .map_addr (map_addr),
        .ext_addr (ext_addr),
        .flag_z   (flag_z),
        .flag_n   (flag_n),
        .next_upc (next_upc)
    );

    // sequencing register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc_q      <= '0;
            uir_ctrl_q <= '0;
        end else begin
            upc_q      <= next_upc;
            uir_ctrl_q <= fetch_w.ctrl;
        end
    end

    // outputs
    always_comb begin
        ctrl_out = uir_ctrl_q;
        upc_out  = upc_q;
    end

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input cword_t            word,
    input logic [UPC_W-1:0]  upc,
    input logic [UPC_W-1:0]  map_addr,
    input logic [UPC_W-1:0]  ext_addr,
    input logic              flag_z,
    input logic              flag_n,
    input logic [CTRL_W-1:0] ctrl_out
);

    logic go;
    always_comb go = word.always_go | (word.test_z & flag_z) | (word.test_n & flag_n);

    AST_UIR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ctrl_out == $past(word.ctrl)); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        word.src == NX_INC |=> upc == UPC_W'($past(upc) + 1)); // R3

    AST_MAP_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (word.src == NX_MAP && go) |=> upc == $past(map_addr)); // R4

    AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (word.src == NX_EXT && go) |=> upc == $past(ext_addr)); // R5

    AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (word.src == NX_BR && go) |=> upc == $past(word.target)); // R6

    AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (word.src != NX_INC && !go) |=> upc == UPC_W'($past(upc) + 1)); // R7

endmodule

bind useq_top useq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (fetch_w),
    .upc      (upc_q),
    .map_addr (map_addr),
    .ext_addr (ext_addr),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .ctrl_out (ctrl_out)
);

// File: tb/useq_top_tb.sv
module useq_top_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] opcode;
    logic       flag_z, flag_n;
    logic [8:0] ext_addr;
    logic [7:0] ctrl_out;
    logic [8:0] upc_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int    m_upc, m_ctrl;
    string tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .flag_z   (flag_z),
        .flag_n   (flag_n),
        .ext_addr (ext_addr),
        .ctrl_out (ctrl_out),
        .upc_out  (upc_out)
    );

    // expected program, written from the requirements (R9, R10)
    task automatic spec_word(input int a, output int c, output int s, output int g,
                             output int tz, output int tn, output int t);
        c = 0; s = 0; g = 0; tz = 0; tn = 0; t = 0;
        if (a == 0)        begin c = 'h01; end
        else if (a == 1)   begin c = 'h02; s = 1; g = 1; end
        else if (a == 16)  begin c = 'h10; end
        else if (a == 17)  begin c = 'h11; s = 3; g = 1; end
        else if (a == 32)  begin c = 'h20; s = 3; tz = 1; t = 40; end
        else if (a == 33)  begin c = 'h21; s = 3; g = 1; t = 32; end
        else if (a == 40)  begin c = 'h28; s = 3; g = 1; end
        else if (a == 60)  begin c = 'h50; s = 3; end
        else if (a == 61)  begin c = 'h51; s = 3; tz = 1; tn = 1; end
        else if (a == 62)  begin c = 'h52; s = 3; g = 1; end
        else if (a == 100) begin c = 'h60; s = 3; g = 1; end
        else if (a == 202) begin c = 'h32; s = 2; tz = 1; end
        else if (a == 203) begin c = 'h33; s = 3; tn = 1; t = 300; end
        else if (a == 204) begin c = 'h34; s = 3; g = 1; end
        else if (a == 300) begin c = 'h40; s = 3; g = 1; end
    endtask

    task automatic chk(input int got, input int exp, input string req);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // called at a falling edge: drive inputs, advance the model, check at next falling edge
    task automatic step(input int opc, input int z, input int n, input int ea);
        int c, s, g, tz, tn, t, starts[4];
        bit go;
        starts = '{16, 32, 202, 60};
        opcode   = 2'(opc);
        flag_z   = 1'(z);
        flag_n   = 1'(n);
        ext_addr = 9'(ea);
        spec_word(m_upc, c, s, g, tz, tn, t);
        go = (g != 0) || (tz != 0 && z != 0) || (tn != 0 && n != 0);
        if (m_upc == 32 || m_upc == 33) tag = "R10";
        else if (m_upc == 0 || m_upc == 1) tag = "R9";
        else if (s == 0) tag = "R3 R8";
        else if (!go) tag = "R7";
        else if (s == 1) tag = "R4";
        else if (s == 2) tag = "R5";
        else tag = "R6";
        m_ctrl = c;
        if (s == 0 || !go) m_upc = (m_upc + 1) % 512;
        else if (s == 1)   m_upc = starts[opc];
        else if (s == 2)   m_upc = ea;
        else               m_upc = t;
        @(negedge clk);
        chk(int'(upc_out), m_upc, tag);
        chk(int'(ctrl_out), m_ctrl, "R2");
    endtask

    task automatic run(input int cycles, input int opc, input int z, input int n, input int ea);
        for (int i = 0; i < cycles; i++) step(opc, z, n, ea);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        int picks[5];
        picks = '{0, 32, 100, 202, 511};
        rst_n = 1'b0; opcode = '0; flag_z = 1'b0; flag_n = 1'b0; ext_addr = '0;
        m_upc = 0; m_ctrl = 0;
        repeat (3) begin
            @(negedge clk);
            chk(int'(upc_out), 0, "R1");
            chk(int'(ctrl_out), 0, "R1");
        end
        rst_n = 1'b1;
        run(12, 0, 0, 0, 0);      // opcode 0 routine
        run(4, 0, 1, 1, 37);      // R8: flags and vector vary on increment words
        run(2, 1, 0, 0, 0);       // fetch, dispatch to loop
        run(9, 1, 0, 0, 0);       // R10: loop spins without Z
        run(5, 1, 1, 0, 0);       // R10: exit through 40
        run(8, 2, 1, 0, 100);     // R5: external vector 100
        run(8, 2, 0, 1, 100);     // R6: N branch to 300
        run(8, 2, 0, 0, 100);     // R7: both conditions false
        run(5, 2, 1, 0, 511);     // R3: wrap 511 -> 0
        run(10, 3, 0, 0, 0);      // R7: never-taken branch at 60, 61 falls through
        run(10, 3, 0, 1, 0);      // R7: either-flag branch on N
        for (int i = 0; i < 400; i++)
            step(int'($urandom_range(3)), int'($urandom_range(1)),
                 int'($urandom_range(1)), picks[$urandom_range(4)]);
        finish_up();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

endmodule